// File: doc/BRIEF.md
# Switch Partition Packet Disposition Filter

This block decides what happens to each transaction-layer packet that arrives at a port of one switch partition. A descriptor comes in: whether the packet is a completion, the index of the port it routes to, whether the switch generated it, and whether it is a configuration request aimed at the upstream port. One cycle later the block returns a disposition: forward with a one-hot destination port mask, flag as an unsupported request, or discard silently.

The rules depend on the partition topology. A partition can be normal, with both an upstream port and downstream ports. It can have an upstream port and no downstream ports. It can lack an upstream port. A partition counts as having no upstream port when its upstream data link is down and the hot-reset-on-link-down control is set. The block also drives, from the topology alone, one flag per port. Each flag tells the link power logic that the port may enter and leave L0s and L1 without waiting on the other side of the partition.

Top module: `tlp_disp_filter`

## Requirements
- R1: `disp_valid_o` is high in the cycle after each cycle with `desc_valid_i` high, and low in the cycle after each cycle with it low. The disposition shown is computed from the descriptor and topology sampled at that earlier edge.
- R2: The disposition codes are 2'b00 forward, 2'b01 unsupported request and 2'b10 silent drop. `disp_mask_o` has exactly one bit set when the code is forward, and is all zeros otherwise.
- R3: When a partition has an upstream port and no downstream ports, a request (`desc_cpl_i`=0) with `desc_cfg_up_i`=1 is forwarded to port `UP_PORT`, whatever its target.
- R4: When a partition has an upstream port and no downstream ports, every completion is an unsupported request. So is every request that is not a configuration request to the upstream port.
- R5: In a partition with no upstream port, a packet whose target is a downstream member port (`dn_mask_i` bit set) is forwarded to that port only.
- R6: In a partition with no upstream port, a packet whose target is not a downstream member port is an unsupported request, unless R7 applies.
- R7: In a partition with no upstream port, a packet with `desc_self_gen_i`=1 whose target is `UP_PORT` is dropped silently (code 2'b10).
- R8: With `hr_link_en_i`=1 and `up_dl_down_i`=1, a partition is treated as having no upstream port, even when `has_up_i`=1.
- R9: In a partition with an upstream port and at least one downstream port, a packet is forwarded to its target port unchanged.
- R10: A target index of `N_PORTS` or above is always an unsupported request.
- R11: `aspm_free_o[UP_PORT]` is high only when the partition has an upstream port and no downstream ports. `aspm_free_o[i]` for any other i is high only when the partition has no upstream port and port i is a downstream member.
- R12: While `rst_ni` is low, `disp_valid_o` is low, and `disp_code_o` and `disp_mask_o` are zero.
- R13: Bit `UP_PORT` of `dn_mask_i` is ignored. It never makes the upstream port a downstream member.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| desc_valid_i | input | 1 | Descriptor present this cycle |
| desc_cpl_i | input | 1 | 1 = completion, 0 = request or message |
| desc_target_i | input | PORT_W | Routing target port index |
| desc_self_gen_i | input | 1 | Packet generated by the switch itself |
| desc_cfg_up_i | input | 1 | Configuration request aimed at the upstream port |
| has_up_i | input | 1 | Partition has an upstream port |
| dn_mask_i | input | N_PORTS | Downstream member ports of the partition |
| hr_link_en_i | input | 1 | Hot-reset-on-link-down control |
| up_dl_down_i | input | 1 | Upstream data link is down |
| disp_valid_o | output | 1 | Disposition valid |
| disp_code_o | output | 2 | Disposition code |
| disp_mask_o | output | N_PORTS | One-hot destination on forward |
| aspm_free_o | output | N_PORTS | Port may change low-power state on its own |

## Verification
A wrong topology decode shows up as a wrong code or mask for a whole class of descriptors. It appears in the cycle after the first affected descriptor. A mistake in the power flags shows up at once, because those flags are combinational from the topology inputs. The sweep covers every topology, target, packet kind and flag combination of a five-port configuration. This includes out-of-range targets, the masked upstream bit, and link-down with the control set and clear. Any misrouted class is therefore seen within one sweep pass.

// File: rtl/tlpf_pkg.sv
package tlpf_pkg;
  typedef enum logic [1:0] {
    DISP_FWD  = 2'b00,
    DISP_UR   = 2'b01,
    DISP_DROP = 2'b10
  } disp_e;
endpackage

// File: rtl/tlpf_topo.sv
module tlpf_topo #(
  parameter int N_PORTS = 4,
  parameter int UP_PORT = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               has_up_i,
  input  logic               hr_link_en_i,
  input  logic               up_dl_down_i,
  input  logic [N_PORTS-1:0] dn_mask_i,
  output logic               no_up_o,
  output logic               no_dn_o,
  output logic [N_PORTS-1:0] dn_eff_o,
  output logic [N_PORTS-1:0] aspm_free_o
);
  always_comb begin
    // link-down with hot reset armed behaves as if the upstream port were absent
    no_up_o = !has_up_i || (hr_link_en_i && up_dl_down_i);
    dn_eff_o = dn_mask_i;
    dn_eff_o[UP_PORT] = 1'b0;
    no_dn_o = (dn_eff_o == '0);
  end

  for (genvar i = 0; i < N_PORTS; i++) begin : g_aspm
    if (i == UP_PORT) begin : g_up
      assign aspm_free_o[i] = !no_up_o && no_dn_o;
    end else begin : g_dn
      assign aspm_free_o[i] = no_up_o && dn_eff_o[i];
    end
  end

  p_aspm_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aspm_free_o[UP_PORT] |-> ($countones(aspm_free_o) == 1));
  p_up_not_member_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dn_eff_o[UP_PORT]);
endmodule

// File: rtl/tlpf_decide.sv
module tlpf_decide
  import tlpf_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int UP_PORT = 0,
  parameter int PORT_W  = 2
) (
  input  logic               cpl_i,
  input  logic [PORT_W-1:0]  target_i,
  input  logic               self_gen_i,
  input  logic               cfg_up_i,
  input  logic               no_up_i,
  input  logic               no_dn_i,
  input  logic [N_PORTS-1:0] dn_eff_i,
  output disp_e              code_o,
  output logic [N_PORTS-1:0] mask_o
);
  localparam logic [PORT_W:0] PORT_LIM = (PORT_W+1)'(N_PORTS);
  localparam logic [PORT_W-1:0] UP_IDX = PORT_W'(UP_PORT);

  logic [N_PORTS-1:0] tgt_oh;
  logic [N_PORTS-1:0] up_oh;
  logic               in_range;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_oh
    assign tgt_oh[i] = (target_i == PORT_W'(i));
    assign up_oh[i]  = (i == UP_PORT);
  end

  assign in_range = ({1'b0, target_i} < PORT_LIM);

  always_comb begin
    code_o = DISP_UR;
    mask_o = '0;
    if (!in_range) begin
      code_o = DISP_UR;
    end else if (no_up_i) begin
      if (self_gen_i && target_i == UP_IDX) begin
        code_o = DISP_DROP;
      end else if ((tgt_oh & dn_eff_i) != '0) begin
        code_o = DISP_FWD;
        mask_o = tgt_oh;
      end
    end else if (no_dn_i) begin
      if (!cpl_i && cfg_up_i) begin
        code_o = DISP_FWD;
        mask_o = up_oh;
      end
    end else begin
      code_o = DISP_FWD;
      mask_o = tgt_oh;
    end
  end
endmodule

// File: rtl/tlp_disp_filter.sv
module tlp_disp_filter
  import tlpf_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int UP_PORT = 0,
  localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               desc_valid_i,
  input  logic               desc_cpl_i,
  input  logic [PORT_W-1:0]  desc_target_i,
  input  logic               desc_self_gen_i,
  input  logic               desc_cfg_up_i,
  input  logic               has_up_i,
  input  logic [N_PORTS-1:0] dn_mask_i,
  input  logic               hr_link_en_i,
  input  logic               up_dl_down_i,
  output logic               disp_valid_o,
  output logic [1:0]         disp_code_o,
  output logic [N_PORTS-1:0] disp_mask_o,
  output logic [N_PORTS-1:0] aspm_free_o
);
  logic               no_up, no_dn;
  logic [N_PORTS-1:0] dn_eff;
  disp_e              nxt_code;
  logic [N_PORTS-1:0] nxt_mask;

  tlpf_topo #(.N_PORTS(N_PORTS), .UP_PORT(UP_PORT)) u_topo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .has_up_i     (has_up_i),
    .hr_link_en_i (hr_link_en_i),
    .up_dl_down_i (up_dl_down_i),
    .dn_mask_i    (dn_mask_i),
    .no_up_o      (no_up),
    .no_dn_o      (no_dn),
    .dn_eff_o     (dn_eff),
    .aspm_free_o  (aspm_free_o)
  );

  tlpf_decide #(.N_PORTS(N_PORTS), .UP_PORT(UP_PORT), .PORT_W(PORT_W)) u_decide (
    .cpl_i      (desc_cpl_i),
    .target_i   (desc_target_i),
    .self_gen_i (desc_self_gen_i),
    .cfg_up_i   (desc_cfg_up_i),
    .no_up_i    (no_up),
    .no_dn_i    (no_dn),
    .dn_eff_i   (dn_eff),
    .code_o     (nxt_code),
    .mask_o     (nxt_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_valid_o <= 1'b0;
      disp_code_o  <= '0;
      disp_mask_o  <= '0;
    end else begin
      disp_valid_o <= desc_valid_i;
      if (desc_valid_i) begin
        disp_code_o <= nxt_code;
        disp_mask_o <= nxt_mask;
      end
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i |=> disp_valid_o);
  p_idle_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !desc_valid_i |=> !disp_valid_o);
  p_fwd_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && disp_code_o == DISP_FWD) |-> ($countones(disp_mask_o) == 1));
  p_nofwd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && disp_code_o != DISP_FWD) |-> (disp_mask_o == '0));
  p_code_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> (disp_code_o != 2'b11));
  p_drop_selfgen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i ##1 (disp_code_o == DISP_DROP) |-> $past(desc_self_gen_i));
endmodule

// File: tb/sim_tlp_disp_filter.sv
module sim_tlp_disp_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;
  localparam int PW = 3;
  localparam int UP = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic desc_valid = 1'b0, desc_cpl = 1'b0, desc_self = 1'b0, desc_cfg = 1'b0;
  logic [PW-1:0] desc_tgt = '0;
  logic has_up = 1'b1, hr_en = 1'b0, dl_down = 1'b0;
  logic [NP-1:0] dn_mask = '0;
  logic disp_valid;
  logic [1:0] disp_code;
  logic [NP-1:0] disp_mask, aspm_free;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlp_disp_filter #(.N_PORTS(NP), .UP_PORT(UP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .desc_valid_i(desc_valid), .desc_cpl_i(desc_cpl),
    .desc_target_i(desc_tgt), .desc_self_gen_i(desc_self), .desc_cfg_up_i(desc_cfg),
    .has_up_i(has_up), .dn_mask_i(dn_mask), .hr_link_en_i(hr_en),
    .up_dl_down_i(dl_down), .disp_valid_o(disp_valid), .disp_code_o(disp_code),
    .disp_mask_o(disp_mask), .aspm_free_o(aspm_free)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input bit nu, input bit nd, input bit rng,
                                   input bit drop, input bit hrx);
    if (!rng) return "R10";
    if (drop) return "R7";
    if (hrx) return "R8";
    if (nu) return "R5/R6";
    if (nd) return "R3/R4";
    return "R9";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<=200000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk("R12 valid", 16'(disp_valid), 16'h0);
    chk("R12 code", 16'(disp_code), 16'h0);
    chk("R12 mask", 16'(disp_mask), 16'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    desc_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1 idle", 16'(disp_valid), 16'h0);

    for (int hu = 0; hu < 2; hu++)
    for (int he = 0; he < 2; he++)
    for (int dd = 0; dd < 2; dd++)
    for (int dm = 0; dm < 32; dm++)
    for (int cp = 0; cp < 2; cp++)
    for (int tg = 0; tg < 8; tg++)
    for (int sg = 0; sg < 2; sg++)
    for (int cf = 0; cf < 2; cf++) begin
      bit nu, nd, rng;
      logic [NP-1:0] dn;
      logic [1:0] e_code;
      logic [NP-1:0] e_mask, e_aspm;
      string rq;
      @(negedge clk);
      has_up = hu[0]; hr_en = he[0]; dl_down = dd[0]; dn_mask = NP'(dm);
      desc_cpl = cp[0]; desc_tgt = PW'(tg); desc_self = sg[0]; desc_cfg = cf[0];
      desc_valid = 1'b1;
      nu = (hu == 0) || (he == 1 && dd == 1);
      dn = NP'(dm) & ~(NP'(1) << UP);
      nd = (dn == 0);
      rng = (tg < NP);
      e_code = 2'b01; e_mask = '0;
      if (!rng) e_code = 2'b01;
      else if (nu) begin
        if (sg == 1 && tg == UP) e_code = 2'b10;
        else if (dn[tg]) begin e_code = 2'b00; e_mask = NP'(1) << tg; end
      end else if (nd) begin
        if (cp == 0 && cf == 1) begin e_code = 2'b00; e_mask = NP'(1) << UP; end
      end else begin
        e_code = 2'b00; e_mask = NP'(1) << tg;
      end
      e_aspm = '0;
      if (nu) e_aspm = dn;
      else if (nd) e_aspm = NP'(1) << UP;
      rq = req_of(nu, nd, rng, e_code == 2'b10, hu == 1 && nu);
      if (tg == 0 && sg == 0 && cf == 0 && cp == 0) begin
        #1;
        chk((dm[0] ? "R13 aspm" : "R11 aspm"), 16'(aspm_free), 16'(e_aspm));
      end
      @(posedge clk); #1;
      chk("R1 valid", 16'(disp_valid), 16'h1);
      chk({rq, " R2 code"}, 16'(disp_code), 16'(e_code));
      chk({rq, " R2 mask"}, 16'(disp_mask), 16'(e_mask));
    end

    @(negedge clk); desc_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1 drop valid", 16'(disp_valid), 16'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule